// File: doc/BRIEF.md
# Page-Aligned Flash Program Splitter

This block takes one program request from a host (a 24-bit start address, a byte length, and the payload as a byte stream) and carries it out on a serial NOR flash through a byte-level shift engine. A flash page program must not run past the end of a page. The block therefore splits the request into chunks. The first chunk stops at the next page boundary. Each later chunk is a full page, except that the last one holds whatever bytes remain.

Each chunk follows the same sequence. The block polls the flash status until the flash is no longer busy. It then sends a write-enable transaction, and finally a program transaction. The program transaction carries the opcode, the chunk's address (start address plus the bytes already written) and the chunk's data. When the request ends, the block reports success or failure and the number of payload bytes it wrote.

A request that would run past the end of the device is refused without any flash traffic. A zero-length request completes at once. If the status poll stays busy for too many reads, the request is abandoned.

Top module: `pgm_splitter`

## Requirements
- R1: After reset, spi_cs, spi_tx_valid, done_valid and dat_ready are low and req_ready is high.
- R2: No program transaction crosses a PAGE_BYTES boundary. The first chunk holds min(len, PAGE_BYTES - start mod PAGE_BYTES) bytes. Each later chunk holds min(PAGE_BYTES, bytes left). The number of program transactions is floor((start+len-1)/PAGE_BYTES) - floor(start/PAGE_BYTES) + 1.
- R3: A program transaction is one chip-select window. It contains opcode 0x02, then the three address bytes with the most significant byte first, then the data bytes. The address equals the start address plus the data bytes already written for this request.
- R4: Before every chunk, the block sends status reads until one returns bit 0 clear. Each status read is a transaction of opcode 0x05 plus one read byte, and bit 0 set in the read byte means busy. After that read, the block sends the write-enable opcode 0x06 as a transaction of its own.
- R5: spi_tx_valid is only high while spi_cs is high. It stays high with a stable spi_tx_byte until spi_tx_done. spi_cs drops between transactions.
- R6: dat_ready is high only in the data phase of a program transaction. The block takes one host byte per engine exchange, and host bytes reach the flash in order, at consecutive addresses.
- R7: On success, done_ok is 1 and done_count equals the request length. The opcode and address bytes are not counted.
- R8: A zero-length request ends with done_ok 1 and done_count 0, and causes no flash traffic.
- R9: A request with start + len > DEV_BYTES ends with done_ok 0 and done_count 0, and causes no flash traffic. A request that ends exactly at DEV_BYTES is accepted.
- R10: After POLL_LIMIT consecutive busy status reads, the request is abandoned. done_ok is 0, and done_count holds the data bytes already written.
- R11: done_valid is a one-cycle pulse. req_ready is high only while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on valid |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Number of bytes to program |
| dat_valid | input | 1 | Host payload byte offered |
| dat_ready | output | 1 | Payload byte taken on valid |
| dat_byte | input | 8 | Payload byte |
| done_valid | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Request completed without error |
| done_count | output | LEN_W | Payload bytes written |
| spi_cs | output | 1 | Flash chip select, active high |
| spi_tx_valid | output | 1 | Byte exchange requested |
| spi_tx_byte | output | 8 | Byte to shift out |
| spi_tx_done | input | 1 | Engine finished the exchange |
| spi_rx_byte | input | 8 | Byte shifted in, valid with spi_tx_done |

## Verification
The bench builds the block with PAGE_BYTES = 16, DEV_BYTES = 128, LEN_W = 9 and POLL_LIMIT = 4. A sweep of start offsets across two pages and every length from 0 to 35 then takes about three hundred requests. That sweep reaches every combination of a short first chunk, whole middle pages and a partial last chunk. A flash model with page-wrapping memory keeps the flash busy for a few reads after each program, so every chunk goes through repeated polling. The model also checks write enable and the chunk address on each program. Requests at the exact device end, one byte past it, and a poll that stays busy in the middle of a request come within a handful of cycles.

// File: rtl/pgm_pkg.sv
// Shared constants and state encoding for the page-aligned program splitter.
package pgm_pkg;
    localparam int ADDR_W     = 24;
    localparam int ADDR_BYTES = 3;
    localparam logic [7:0] OP_STATUS = 8'h05;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] DUMMY     = 8'h00;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL_OP,
        ST_POLL_RD,
        ST_WREN,
        ST_PROG_OP,
        ST_ADDR,
        ST_DATA,
        ST_GAP,
        ST_FIN
    } seq_state_e;
endpackage

// File: rtl/pgm_req_check.sv
// Classifies an incoming request: empty, or running past the device end.
// Assumes DEV_BYTES fits in the widened sum width.
module pgm_req_check #(
    parameter int          LEN_W     = 24,
    parameter int unsigned DEV_BYTES = 32'h0100_0000
) (
    input  logic [pgm_pkg::ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]           len,
    output logic                       is_empty,
    output logic                       is_over
);
    localparam int SW = ((pgm_pkg::ADDR_W > LEN_W) ? pgm_pkg::ADDR_W : LEN_W) + 2;

    logic [SW-1:0] end_pos;

    // Compute the exclusive end address in a width that cannot wrap.
    always_comb begin
        end_pos  = SW'(addr) + SW'(len);
        is_empty = (len == '0);
        is_over  = (end_pos > SW'(DEV_BYTES));
    end
endmodule

// File: rtl/pgm_chunk_calc.sv
// Computes the length of the next program chunk: the bytes left, cut at the
// next page boundary. Assumes PAGE_BYTES is a power of two.
module pgm_chunk_calc #(
    parameter int PAGE_BYTES = 256,
    parameter int LEN_W      = 24,
    localparam int PAGE_W    = $clog2(PAGE_BYTES)
) (
    input  logic [PAGE_W-1:0] page_off,
    input  logic [LEN_W-1:0]  left,
    output logic [LEN_W-1:0]  chunk
);
    localparam int CW = ((LEN_W > PAGE_W + 1) ? LEN_W : PAGE_W + 1);

    logic [CW-1:0] room;
    logic [CW-1:0] left_w;
    logic [CW-1:0] pick;

    // Room to the page end, then the smaller of room and bytes left.
    always_comb begin
        room   = CW'(PAGE_BYTES) - CW'(page_off);
        left_w = CW'(left);
        pick   = (left_w < room) ? left_w : room;
        chunk  = LEN_W'(pick);
    end
endmodule

// File: rtl/pgm_seq.sv
// Transaction sequencer: per chunk it runs status polls, a write enable and a
// page program, one byte exchange at a time with the shift engine.
// Assumes the engine answers each raised spi_tx_valid with one spi_tx_done.
module pgm_seq #(
    parameter int          PAGE_BYTES = 256,
    parameter int          LEN_W      = 24,
    parameter int unsigned POLL_LIMIT = 100000,
    parameter logic [7:0]  BUSY_MASK  = 8'h01,
    localparam int PAGE_W = $clog2(PAGE_BYTES),
    localparam int POLL_W = $clog2(POLL_LIMIT + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [pgm_pkg::ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]           req_len,
    input  logic                       req_empty,
    input  logic                       req_over,
    input  logic                       dat_valid,
    output logic                       dat_ready,
    input  logic [7:0]                 dat_byte,
    output logic [PAGE_W-1:0]          page_off,
    output logic [LEN_W-1:0]           bytes_left,
    input  logic [LEN_W-1:0]           chunk_in,
    output logic                       done_valid,
    output logic                       done_ok,
    output logic [LEN_W-1:0]           done_count,
    output logic                       spi_cs,
    output logic                       spi_tx_valid,
    output logic [7:0]                 spi_tx_byte,
    input  logic                       spi_tx_done,
    input  logic [7:0]                 spi_rx_byte
);
    import pgm_pkg::*;

    seq_state_e          state;
    seq_state_e          gap_next;
    logic [ADDR_W-1:0]   cur_addr;
    logic [LEN_W-1:0]    remaining;
    logic [LEN_W-1:0]    sent;
    logic [LEN_W-1:0]    chunk_left;
    logic [1:0]          addr_idx;
    logic [POLL_W-1:0]   poll_cnt;
    logic                tx_valid;
    logic [7:0]          tx_byte;
    logic                ok_q;
    logic                in_xact;
    logic                issue;
    logic                busy_rd;
    logic [7:0]          next_byte;

    // Chip select covers every state that belongs to a flash transaction.
    always_comb begin
        in_xact = (state == ST_POLL_OP) || (state == ST_POLL_RD) ||
                  (state == ST_WREN)    || (state == ST_PROG_OP) ||
                  (state == ST_ADDR)    || (state == ST_DATA);
    end

    // Pick the byte to launch next and decide whether it can launch now.
    always_comb begin
        next_byte = DUMMY;
        case (state)
            ST_POLL_OP: next_byte = OP_STATUS;
            ST_POLL_RD: next_byte = DUMMY;
            ST_WREN:    next_byte = OP_WREN;
            ST_PROG_OP: next_byte = OP_PROG;
            ST_ADDR: begin
                case (addr_idx)
                    2'd0:    next_byte = cur_addr[23:16];
                    2'd1:    next_byte = cur_addr[15:8];
                    default: next_byte = cur_addr[7:0];
                endcase
            end
            ST_DATA:    next_byte = dat_byte;
            default:    next_byte = DUMMY;
        endcase
        issue   = in_xact && !tx_valid && ((state != ST_DATA) || dat_valid);
        busy_rd = (spi_rx_byte & BUSY_MASK) != 8'h00;
    end

    // Main sequencer: request intake, byte launch and per-exchange advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            gap_next   <= ST_IDLE;
            cur_addr   <= '0;
            remaining  <= '0;
            sent       <= '0;
            chunk_left <= '0;
            addr_idx   <= '0;
            poll_cnt   <= '0;
            tx_valid   <= 1'b0;
            tx_byte    <= '0;
            ok_q       <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_addr  <= req_addr;
                        remaining <= req_len;
                        sent      <= '0;
                        poll_cnt  <= '0;
                        if (req_empty) begin
                            ok_q  <= 1'b1;
                            state <= ST_FIN;
                        end else if (req_over) begin
                            ok_q  <= 1'b0;
                            state <= ST_FIN;
                        end else begin
                            state <= ST_POLL_OP;
                        end
                    end
                end
                ST_GAP: state <= gap_next;
                ST_FIN: state <= ST_IDLE;
                default: begin
                    if (issue) begin
                        tx_valid <= 1'b1;
                        tx_byte  <= next_byte;
                        if (state == ST_PROG_OP) begin
                            chunk_left <= chunk_in;
                        end
                    end else if (tx_valid && spi_tx_done) begin
                        tx_valid <= 1'b0;
                        case (state)
                            ST_POLL_OP: state <= ST_POLL_RD;
                            ST_POLL_RD: begin
                                state <= ST_GAP;
                                if (!busy_rd) begin
                                    poll_cnt <= '0;
                                    gap_next <= ST_WREN;
                                end else if (poll_cnt == POLL_W'(POLL_LIMIT - 1)) begin
                                    ok_q     <= 1'b0;
                                    gap_next <= ST_FIN;
                                end else begin
                                    poll_cnt <= poll_cnt + 1'b1;
                                    gap_next <= ST_POLL_OP;
                                end
                            end
                            ST_WREN: begin
                                state    <= ST_GAP;
                                gap_next <= ST_PROG_OP;
                            end
                            ST_PROG_OP: begin
                                addr_idx <= '0;
                                state    <= ST_ADDR;
                            end
                            ST_ADDR: begin
                                if (addr_idx == 2'(ADDR_BYTES - 1)) begin
                                    state <= ST_DATA;
                                end else begin
                                    addr_idx <= addr_idx + 1'b1;
                                end
                            end
                            ST_DATA: begin
                                sent       <= sent + 1'b1;
                                cur_addr   <= cur_addr + 1'b1;
                                remaining  <= remaining - 1'b1;
                                chunk_left <= chunk_left - 1'b1;
                                if (chunk_left == LEN_W'(1)) begin
                                    state <= ST_GAP;
                                    if (remaining == LEN_W'(1)) begin
                                        ok_q     <= 1'b1;
                                        gap_next <= ST_FIN;
                                    end else begin
                                        gap_next <= ST_POLL_OP;
                                    end
                                end
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    // Drive outputs from the sequencer state.
    always_comb begin
        req_ready    = (state == ST_IDLE);
        dat_ready    = (state == ST_DATA) && !tx_valid;
        done_valid   = (state == ST_FIN);
        done_ok      = ok_q;
        done_count   = sent;
        spi_cs       = in_xact;
        spi_tx_valid = tx_valid;
        spi_tx_byte  = tx_byte;
        page_off     = cur_addr[PAGE_W-1:0];
        bytes_left   = remaining;
    end

    AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_tx_valid && !spi_tx_done) |=> (spi_tx_valid && $stable(spi_tx_byte))) // R5
        else $error("tx byte dropped before done");
    AST_CHUNK_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && state == ST_PROG_OP) |->
            ((chunk_in != '0) && ((PAGE_W + LEN_W + 1)'(page_off) + (PAGE_W + LEN_W + 1)'(chunk_in)
              <= (PAGE_W + LEN_W + 1)'(PAGE_BYTES)))) // R2
        else $error("chunk crosses page");
    AST_CHUNK_LE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && state == ST_PROG_OP) |-> (chunk_in <= remaining)) // R2
        else $error("chunk longer than request");
    AST_DATA_IN_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
        dat_ready |-> (chunk_left != '0)) // R6
        else $error("data accepted outside chunk");
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_empty) |=> (!spi_cs && done_valid)) // R8
        else $error("empty request touched flash");
    AST_OVER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_over) |=> (!spi_cs && done_valid && !done_ok)) // R9
        else $error("oversize request touched flash");
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid) // R11
        else $error("done longer than one cycle");
    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt < POLL_W'(POLL_LIMIT)) // R10
        else $error("poll counter overrun");
endmodule

// File: rtl/pgm_splitter.sv
// Top of the page-aligned flash program splitter: request classification,
// chunk sizing and the transaction sequencer. Assumes a byte-level shift
// engine that returns one spi_tx_done per spi_tx_valid.
module pgm_splitter #(
    parameter int          PAGE_BYTES = 256,
    parameter int unsigned DEV_BYTES  = 32'h0100_0000,
    parameter int          LEN_W      = 24,
    parameter int unsigned POLL_LIMIT = 100000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [pgm_pkg::ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]           req_len,
    input  logic                       dat_valid,
    output logic                       dat_ready,
    input  logic [7:0]                 dat_byte,
    output logic                       done_valid,
    output logic                       done_ok,
    output logic [LEN_W-1:0]           done_count,
    output logic                       spi_cs,
    output logic                       spi_tx_valid,
    output logic [7:0]                 spi_tx_byte,
    input  logic                       spi_tx_done,
    input  logic [7:0]                 spi_rx_byte
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    logic              req_empty;
    logic              req_over;
    logic [PAGE_W-1:0] page_off;
    logic [LEN_W-1:0]  bytes_left;
    logic [LEN_W-1:0]  chunk_len;

    pgm_req_check #(.LEN_W(LEN_W), .DEV_BYTES(DEV_BYTES)) u_check (
        .addr     (req_addr),
        .len      (req_len),
        .is_empty (req_empty),
        .is_over  (req_over)
    );

    pgm_chunk_calc #(.PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)) u_chunk (
        .page_off (page_off),
        .left     (bytes_left),
        .chunk    (chunk_len)
    );

    pgm_seq #(.PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W), .POLL_LIMIT(POLL_LIMIT)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .req_empty    (req_empty),
        .req_over     (req_over),
        .dat_valid    (dat_valid),
        .dat_ready    (dat_ready),
        .dat_byte     (dat_byte),
        .page_off     (page_off),
        .bytes_left   (bytes_left),
        .chunk_in     (chunk_len),
        .done_valid   (done_valid),
        .done_ok      (done_ok),
        .done_count   (done_count),
        .spi_cs       (spi_cs),
        .spi_tx_valid (spi_tx_valid),
        .spi_tx_byte  (spi_tx_byte),
        .spi_tx_done  (spi_tx_done),
        .spi_rx_byte  (spi_rx_byte)
    );
endmodule

// File: tb/pgm_splitter_tb_top.sv
// Bench: small-page configuration, sweep of start offsets and lengths, plus
// device-end, empty and stuck-busy cases, against a page-wrapping flash model.
module pgm_splitter_tb_top;
    localparam int P     = 16;
    localparam int DEV   = 128;
    localparam int LW    = 9;
    localparam int PLIM  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [23:0]   req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          dat_valid = 1'b0;
    logic          dat_ready;
    logic [7:0]    dat_byte = '0;
    logic          done_valid;
    logic          done_ok;
    logic [LW-1:0] done_count;
    logic          spi_cs;
    logic          spi_tx_valid;
    logic [7:0]    spi_tx_byte;
    logic          spi_tx_done;
    logic [7:0]    spi_rx_byte;

    always #10 clk = ~clk;

    pgm_splitter #(.PAGE_BYTES(P), .DEV_BYTES(DEV), .LEN_W(LW), .POLL_LIMIT(PLIM)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
        .done_valid(done_valid), .done_ok(done_ok), .done_count(done_count),
        .spi_cs(spi_cs), .spi_tx_valid(spi_tx_valid), .spi_tx_byte(spi_tx_byte),
        .spi_tx_done(spi_tx_done), .spi_rx_byte(spi_rx_byte)
    );

    int checks = 0;
    int fails  = 0;
    int mchecks = 0;
    int mfails  = 0;
    int cycles  = 0;

    // Flash model state
    logic [7:0] mem [DEV];
    logic [7:0] exp_mem [DEV];
    logic       pend;
    int   idx, op, pp_addr, pp_n;
    bit   wel, idle_seen, stuck, cs_q;
    int   busy_cnt;
    int   tot_bytes = 0, n_chunks = 0, stuck_reads = 0, n_polls = 0;
    bit   stick_arm = 0, stick_clear = 0;
    int   exp_start = 0, exp_base = 0;
    logic [7:0] resp;

    // Byte engine plus serial flash model with page-wrapping program.
    always @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0; spi_tx_done <= 1'b0; spi_rx_byte <= 8'h00;
            idx = 0; op = 0; pp_addr = 0; pp_n = 0;
            wel = 0; idle_seen = 0; stuck = 0; cs_q = 0; busy_cnt = 0;
            for (int i = 0; i < DEV; i++) mem[i] = 8'h00;
        end else begin
            spi_tx_done <= 1'b0;
            if (stick_clear) stuck = 0;
            if (spi_tx_valid && !spi_tx_done && !pend) pend <= 1'b1;
            if (pend) begin
                pend <= 1'b0;
                spi_tx_done <= 1'b1;
                resp = 8'h00;
                mchecks++;
                if (!spi_cs) begin
                    mfails++;
                    $display("FAIL R5: exchange without chip select, act cs=%0d exp 1", spi_cs);
                end
                if (idx == 0) begin
                    op = spi_tx_byte;
                    if (spi_tx_byte == 8'h06) wel = 1;
                    if (spi_tx_byte == 8'h02) begin
                        mchecks++;
                        if (!(wel && idle_seen)) begin
                            mfails++;
                            $display("FAIL R4: program without idle poll/write enable, act wel=%0d idle=%0d exp 1 1",
                                     wel, idle_seen);
                        end
                    end
                end else if (op == 8'h05) begin
                    resp = {6'b0, wel, (stuck || busy_cnt > 0)};
                    n_polls++;
                    if (stuck) stuck_reads++;
                    if (!(stuck || busy_cnt > 0)) idle_seen = 1;
                    if (busy_cnt > 0) busy_cnt--;
                end else if (op == 8'h02) begin
                    if (idx <= 3) pp_addr = ((pp_addr << 8) | spi_tx_byte) & 32'hFF_FFFF;
                    else begin
                        mem[(((pp_addr & ~(P-1)) | ((pp_addr + pp_n) & (P-1))) % DEV)] = spi_tx_byte;
                        pp_n++;
                    end
                end
                spi_rx_byte <= resp;
                idx++;
            end
            if (cs_q && !spi_cs) begin
                if (op == 8'h02) begin
                    mchecks++;
                    if (pp_n == 0 || (pp_addr % P) + pp_n > P) begin
                        mfails++;
                        $display("FAIL R2: chunk at %0d len %0d, act end offset %0d exp <= %0d",
                                 pp_addr, pp_n, (pp_addr % P) + pp_n, P);
                    end
                    mchecks++;
                    if (pp_addr != exp_start + (tot_bytes - exp_base)) begin
                        mfails++;
                        $display("FAIL R3: chunk address act %0d exp %0d",
                                 pp_addr, exp_start + (tot_bytes - exp_base));
                    end
                    tot_bytes += pp_n;
                    n_chunks++;
                    wel = 0; idle_seen = 0; busy_cnt = 2; pp_n = 0;
                    if (stick_arm) stuck = 1;
                end
                op = 0;
            end
            if (!spi_cs) idx = 0;
            cs_q = spi_cs;
        end
    end

    task automatic chk(input bit good, input string req, input int act, input int exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + mchecks, fails + mfails);
    endtask

    function automatic logic [7:0] pat(input int s, input int l, input int i, input int n);
        return 8'((s * 37 + l * 11 + i * 5 + n) & 255);
    endfunction

    int req_no = 0;

    // Issue one request, stream its payload, and collect the completion.
    task automatic run_req(input int s, input int l, output bit ok, output int cnt);
        bit over = 0;
        int n = req_no;
        req_no++;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 24'(s); req_len = LW'(l);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        fork
            begin
                int k = 0;
                while (k < l && !over) begin
                    @(negedge clk);
                    dat_valid = 1'b1;
                    dat_byte  = pat(s, l, k, n);
                    if (dat_ready) k++;
                end
                @(negedge clk);
                dat_valid = 1'b0;
            end
            begin
                while (!done_valid) @(negedge clk);
                ok = done_ok; cnt = int'(done_count);
                over = 1;
                @(negedge clk);
                chk(!done_valid && req_ready, "R11", {30'b0, done_valid, req_ready}, 1);
            end
        join
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog: act %0d cycles exp completion", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        bit ok; int cnt; int c0; int p0; int first;
        int starts [8] = '{0, 1, 7, 14, 15, 16, 17, 31};
        for (int i = 0; i < DEV; i++) exp_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(!spi_cs && !spi_tx_valid && !done_valid && !dat_ready && req_ready,
            "R1", {27'b0, spi_cs, spi_tx_valid, done_valid, dat_ready, req_ready}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!spi_cs && req_ready, "R1", {30'b0, spi_cs, req_ready}, 1);

        // Sweep of start offsets and lengths (R2 R3 R6 R7 R8)
        foreach (starts[si]) begin
            for (int l = 0; l <= 35; l++) begin
                int s = starts[si];
                exp_start = s; exp_base = tot_bytes; c0 = n_chunks; p0 = n_polls;
                for (int i = 0; i < l; i++) exp_mem[s + i] = pat(s, l, i, req_no);
                run_req(s, l, ok, cnt);
                chk(ok == 1, "R7 ok", ok, 1);
                chk(cnt == l, "R7 count", cnt, l);
                if (l == 0) begin
                    chk(n_chunks == c0 && n_polls == p0, "R8 traffic", n_polls - p0, 0);
                end else begin
                    chk(n_chunks - c0 == (s + l - 1) / P - s / P + 1, "R2 chunks",
                        n_chunks - c0, (s + l - 1) / P - s / P + 1);
                end
                begin
                    int bad = 0;
                    for (int i = 0; i < DEV; i++) if (mem[i] !== exp_mem[i]) bad++;
                    chk(bad == 0, "R6 payload bytes", bad, 0);
                end
            end
        end

        // R9 rejection one byte past the device end
        c0 = n_chunks; p0 = n_polls;
        run_req(DEV - 8, 9, ok, cnt);
        chk(ok == 0, "R9 ok", ok, 0);
        chk(cnt == 0, "R9 count", cnt, 0);
        chk(n_polls == p0 && n_chunks == c0, "R9 traffic", n_polls - p0, 0);

        // R9 boundary: request ending exactly at the device end is accepted
        exp_start = DEV - 1; exp_base = tot_bytes;
        exp_mem[DEV - 1] = pat(DEV - 1, 1, 0, req_no);
        run_req(DEV - 1, 1, ok, cnt);
        chk(ok == 1 && cnt == 1, "R9 boundary", cnt, 1);
        chk(mem[DEV - 1] == exp_mem[DEV - 1], "R9 boundary byte", mem[DEV - 1], exp_mem[DEV - 1]);

        // R10 poll timeout after the first chunk of a two-page request
        exp_start = 10; exp_base = tot_bytes; first = stuck_reads;
        for (int i = 0; i < 6; i++) exp_mem[10 + i] = pat(10, 20, i, req_no);
        stick_arm = 1;
        run_req(10, 20, ok, cnt);
        stick_arm = 0;
        chk(ok == 0, "R10 ok", ok, 0);
        chk(cnt == 6, "R10 count", cnt, 6);
        chk(stuck_reads - first == PLIM, "R10 busy reads", stuck_reads - first, PLIM);
        stick_clear = 1;
        @(negedge clk);
        stick_clear = 0;
        begin
            int bad = 0;
            for (int i = 0; i < DEV; i++) if (mem[i] !== exp_mem[i]) bad++;
            chk(bad == 0, "R10 partial payload", bad, 0);
        end

        // Recovery after the abort: a plain request succeeds (R7)
        exp_start = 40; exp_base = tot_bytes;
        for (int i = 0; i < 5; i++) exp_mem[40 + i] = pat(40, 5, i, req_no);
        run_req(40, 5, ok, cnt);
        chk(ok == 1 && cnt == 5, "R7 after abort", cnt, 5);

        summary();
        $finish;
    end
endmodule